// File: doc/BRIEF.md
# Cascaded two-level interrupt controller

This block collects level-sensitive interrupt requests from two banks and presents them to a processor as one interrupt line. The main bank has 40 channels. The auxiliary bank has 32 channels, and their combined request feeds main channel 0. Software reaches the block over a simple 32-bit register bus. Through that bus it can enable or disable any channel, acknowledge latched requests, read which main channel should be serviced first, and read the auxiliary bank's status.

Each channel keeps a latched pending bit and an enable bit. The enable bits change only through write-one-to-set and write-one-to-clear registers, so bits written as 0 leave the other channels alone. A pending bit follows its input while the input is high. It clears only when software acknowledges it after the input has dropped. A table of 40 six-bit channel routing entries is held alongside, and software can read and write it.

Top module: `irqc_top`

## Requirements
- R1: After reset, every pending and enable bit is 0, `cpu_irq` is low, the index register (0x40) reads 0, and routing entry n (at 0x200 + 4·n) reads n.
- R2: A main or auxiliary input that is high before a rising clock edge sets that channel's pending bit at that edge, whether or not the channel is enabled.
- R3: Writing to a main enable-set word (0x20 for channels 0–31, 0x24 for channels 32–39, bit k = channel 32·w + k) sets the enable of every channel written as 1 and leaves the others unchanged. Reading either address returns the enable word.
- R4: Writing a 1 to a bit of a disable word (0x30/0x34 for the main bank, 0x98 for the auxiliary bank) clears that enable at the next edge. Bits written as 0 have no effect.
- R5: Writing a 1 to an acknowledge word (0x10/0x14 for the main bank, 0x88 for the auxiliary bank) clears the pending bit only if that channel's input is low at that edge. Otherwise the bit stays set. Reading 0x10/0x14 returns the main pending words.
- R6: The auxiliary status word at 0x80 returns one pending bit per auxiliary channel, with bit 0 being channel 0, independent of enables. Writing to 0x90 sets auxiliary enables, and reading 0x90 or 0x98 returns them.
- R7: Whenever any auxiliary channel is both pending and enabled, main channel 0's pending bit is set at the next edge.
- R8: The index register (0x40, bits [5:0]) returns the lowest-numbered main channel that is both pending and enabled.
- R9: An index value of 0 while `cpu_irq` is high means the auxiliary bank needs service. When no main channel is active, the index reads 0 and `cpu_irq` is low.
- R10: `cpu_irq` is high exactly when at least one main channel is both pending and enabled. It responds in the same cycle as the state change.
- R11: A write to 0x200 + 4·n (n < 40) stores bits [5:0] into routing entry n. Reads return that value with bits [31:6] as 0, and the other entries are unaffected.
- R12: A read strobe registers the addressed value, and `bus_rdata` holds it from the following edge. Unmapped addresses, such as 0x00 and 0x300, read as 0.
- R13: Bits of word 0x24/0x34/0x14 above channel 39 are ignored and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_src | input | NPRI (40) | Level request inputs of the main bank |
| sec_src | input | NSEC (32) | Level request inputs of the auxiliary bank |
| bus_addr | input | AW (10) | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DW (32) | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | DW (32) | Registered read data |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
A main input raised before edge k shows up in the pending state after edge k. An auxiliary input reaches main channel 0's pending bit one edge later, at k+1. Enable and acknowledge writes take effect at the edge that samples the strobe, and `cpu_irq` follows in the same cycle, while read data appears one edge after the read strobe. The bench drives every input on the falling edge. Its write and read tasks each span whole cycles and sample on a falling edge. For the two-edge cascade path it waits an explicit extra cycle, so every check falls after the edge at which the result is due.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // register byte offsets; the main bank words sit 4 bytes apart
    localparam int unsigned OFS_PACK   = 32'h010;
    localparam int unsigned OFS_PENA   = 32'h020;
    localparam int unsigned OFS_PDIS   = 32'h030;
    localparam int unsigned OFS_INDEX  = 32'h040;
    localparam int unsigned OFS_SSTAT  = 32'h080;
    localparam int unsigned OFS_SACK   = 32'h088;
    localparam int unsigned OFS_SENA   = 32'h090;
    localparam int unsigned OFS_SDIS   = 32'h098;
    localparam int unsigned OFS_ROUTE  = 32'h200;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_PACK,
        RK_PENA,
        RK_PDIS,
        RK_INDEX,
        RK_SSTAT,
        RK_SACK,
        RK_SENA,
        RK_SDIS,
        RK_ROUTE
    } reg_kind_e;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int AW   = 10,
    parameter int NPW  = 2,
    parameter int NENT = 40,
    parameter int WW   = 1,
    parameter int XW   = 6
) (
    input  logic [AW-1:0] addr,
    output reg_kind_e     kind,
    output logic [WW-1:0] word,
    output logic [XW-1:0] ent
);

    logic [31:0] a;

    always_comb begin
        a    = 32'(addr);
        kind = RK_NONE;
        word = '0;
        ent  = '0;
        if (a[1:0] == 2'b00) begin
            if (a >= OFS_PACK && a < OFS_PACK + 4 * NPW) begin
                kind = RK_PACK;
                word = WW'((a - OFS_PACK) >> 2);
            end else if (a >= OFS_PENA && a < OFS_PENA + 4 * NPW) begin
                kind = RK_PENA;
                word = WW'((a - OFS_PENA) >> 2);
            end else if (a >= OFS_PDIS && a < OFS_PDIS + 4 * NPW) begin
                kind = RK_PDIS;
                word = WW'((a - OFS_PDIS) >> 2);
            end else if (a == OFS_INDEX) begin
                kind = RK_INDEX;
            end else if (a == OFS_SSTAT) begin
                kind = RK_SSTAT;
            end else if (a == OFS_SACK) begin
                kind = RK_SACK;
            end else if (a == OFS_SENA) begin
                kind = RK_SENA;
            end else if (a == OFS_SDIS) begin
                kind = RK_SDIS;
            end else if (a >= OFS_ROUTE && a < OFS_ROUTE + 4 * NENT) begin
                kind = RK_ROUTE;
                ent  = XW'((a - OFS_ROUTE) >> 2);
            end
        end
    end

endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] en_set,
    input  logic [N-1:0] en_clr,
    input  logic [N-1:0] pd_clr,
    output logic [N-1:0] pend,
    output logic [N-1:0] en
);

    // a high level keeps its pending bit set even against an acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
            en   <= '0;
        end else begin
            pend <= lvl | (pend & ~pd_clr);
            en   <= (en | en_set) & ~en_clr;
        end
    end

endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
    parameter int N  = 40,
    parameter int IW = 6
) (
    input  logic [N-1:0]  act,
    output logic [IW-1:0] idx,
    output logic          hit
);

    // scan downward so the lowest active channel is the last assignment
    always_comb begin
        idx = '0;
        hit = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (act[i]) begin
                idx = IW'(i);
                hit = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irqc_route.sv
module irqc_route #(
    parameter int NENT = 40,
    parameter int VW   = 6,
    parameter int XW   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [XW-1:0] widx,
    input  logic [VW-1:0] wval,
    input  logic [XW-1:0] ridx,
    output logic [VW-1:0] rval
);

    logic [VW-1:0] tbl [NENT];

    for (genvar n = 0; n < NENT; n++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                tbl[n] <= VW'(n);
            else if (we && widx == XW'(n))
                tbl[n] <= wval;
        end
    end

    always_comb begin
        rval = '0;
        for (int n = 0; n < NENT; n++)
            if (ridx == XW'(n))
                rval = tbl[n];
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NPRI = 40,
    parameter int NSEC = 32,
    parameter int DW   = 32,
    parameter int AW   = 10,
    parameter int IW   = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPRI-1:0] pri_src,
    input  logic [NSEC-1:0] sec_src,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic            bus_rd,
    output logic [DW-1:0]   bus_rdata,
    output logic            cpu_irq
);

    localparam int NPW = (NPRI + DW - 1) / DW;
    localparam int WW  = (NPW > 1) ? $clog2(NPW) : 1;
    localparam int XW  = (NPRI > 1) ? $clog2(NPRI) : 1;

    reg_kind_e       kind;
    logic [WW-1:0]   word;
    logic [XW-1:0]   ent;

    logic [NPW*DW-1:0] wmask;
    logic [NPW*DW-1:0] pend_pad;
    logic [NPW*DW-1:0] en_pad;
    logic [NPRI-1:0]   pri_in;
    logic [NPRI-1:0]   pri_pend;
    logic [NPRI-1:0]   pri_en;
    logic [NPRI-1:0]   p_set;
    logic [NPRI-1:0]   p_clr;
    logic [NPRI-1:0]   p_ack;
    logic [NSEC-1:0]   sec_pend;
    logic [NSEC-1:0]   sec_en;
    logic [NSEC-1:0]   s_set;
    logic [NSEC-1:0]   s_clr;
    logic [NSEC-1:0]   s_ack;
    logic              sec_any;
    logic [IW-1:0]     pri_idx;
    logic              pri_hit;
    logic [IW-1:0]     route_val;
    logic              route_we;
    logic [DW-1:0]     rd_mux;

    irqc_decode #(
        .AW(AW), .NPW(NPW), .NENT(NPRI), .WW(WW), .XW(XW)
    ) u_dec (
        .addr(bus_addr),
        .kind(kind),
        .word(word),
        .ent (ent)
    );

    // spread the written word over the main bank's flat bit vector
    always_comb begin
        wmask = '0;
        wmask[word*DW +: DW] = bus_wdata;
    end

    assign p_set = (bus_wr && kind == RK_PENA) ? wmask[NPRI-1:0] : '0;
    assign p_clr = (bus_wr && kind == RK_PDIS) ? wmask[NPRI-1:0] : '0;
    assign p_ack = (bus_wr && kind == RK_PACK) ? wmask[NPRI-1:0] : '0;
    assign s_set = (bus_wr && kind == RK_SENA) ? bus_wdata[NSEC-1:0] : '0;
    assign s_clr = (bus_wr && kind == RK_SDIS) ? bus_wdata[NSEC-1:0] : '0;
    assign s_ack = (bus_wr && kind == RK_SACK) ? bus_wdata[NSEC-1:0] : '0;

    irqc_bank #(.N(NSEC)) u_sec (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (sec_src),
        .en_set(s_set),
        .en_clr(s_clr),
        .pd_clr(s_ack),
        .pend  (sec_pend),
        .en    (sec_en)
    );

    // auxiliary summary is one more request level on main channel 0
    assign sec_any = |(sec_pend & sec_en);
    assign pri_in  = pri_src | {{(NPRI-1){1'b0}}, sec_any};

    irqc_bank #(.N(NPRI)) u_pri (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (pri_in),
        .en_set(p_set),
        .en_clr(p_clr),
        .pd_clr(p_ack),
        .pend  (pri_pend),
        .en    (pri_en)
    );

    irqc_pick #(.N(NPRI), .IW(IW)) u_pick (
        .act(pri_pend & pri_en),
        .idx(pri_idx),
        .hit(pri_hit)
    );

    assign cpu_irq  = pri_hit;
    assign route_we = bus_wr && kind == RK_ROUTE;

    irqc_route #(.NENT(NPRI), .VW(IW), .XW(XW)) u_route (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (route_we),
        .widx (ent),
        .wval (bus_wdata[IW-1:0]),
        .ridx (ent),
        .rval (route_val)
    );

    always_comb begin
        pend_pad = '0;
        en_pad   = '0;
        pend_pad[NPRI-1:0] = pri_pend;
        en_pad[NPRI-1:0]   = pri_en;
    end

    always_comb begin
        rd_mux = '0;
        unique case (kind)
            RK_PACK:           rd_mux = pend_pad[word*DW +: DW];
            RK_PENA, RK_PDIS:  rd_mux = en_pad[word*DW +: DW];
            RK_INDEX:          rd_mux = DW'(pri_idx);
            RK_SSTAT, RK_SACK: rd_mux = DW'(sec_pend);
            RK_SENA, RK_SDIS:  rd_mux = DW'(sec_en);
            RK_ROUTE:          rd_mux = DW'(route_val);
            default:           rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int NPRI = 40,
    parameter int NSEC = 32,
    parameter int DW   = 32,
    parameter int AW   = 10,
    parameter int IW   = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NPRI-1:0] pri_in,
    input logic [NPRI-1:0] pri_pend,
    input logic [NPRI-1:0] pri_en,
    input logic [NSEC-1:0] sec_src,
    input logic [NSEC-1:0] sec_pend,
    input logic [NSEC-1:0] sec_en,
    input logic [IW-1:0]   pri_idx,
    input logic            cpu_irq,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_wr,
    input logic [DW-1:0]   bus_wdata
);

    logic            armed;
    logic [NPRI-1:0] below;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assign below = (NPRI'(1) << pri_idx) - NPRI'(1);

    // R2: a high level is latched at the next edge
    a_r2_level_latch: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (((pri_pend & $past(pri_in)) == $past(pri_in)) &&
                   ((sec_pend & $past(sec_src)) == $past(sec_src))));

    // R4: auxiliary disable clears the written bits
    a_r4_sec_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && bus_wr && bus_addr == AW'(32'h098)) |=>
            ((sec_en & $past(bus_wdata[NSEC-1:0])) == '0));

    // R5: a pending bit can only drop after its input was low
    a_r5_clear_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (($past(pri_pend) & ~pri_pend & $past(pri_in)) == '0));

    // R7: an active auxiliary channel raises main channel 0
    a_r7_cascade: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(|(sec_pend & sec_en))) |-> pri_pend[0]);

    // R8: the reported channel is active and none below it is
    a_r8_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (pri_pend[pri_idx] && pri_en[pri_idx] &&
                     ((pri_pend & pri_en & below) == '0)));

    // R9: idle output reports index 0
    a_r9_idle_index: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_irq |-> (pri_idx == '0));

endmodule

bind irqc_top irqc_chk #(
    .NPRI(NPRI), .NSEC(NSEC), .DW(DW), .AW(AW), .IW(IW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pri_in   (pri_in),
    .pri_pend (pri_pend),
    .pri_en   (pri_en),
    .sec_src  (sec_src),
    .sec_pend (sec_pend),
    .sec_en   (sec_en),
    .pri_idx  (pri_idx),
    .cpu_irq  (cpu_irq),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata)
);

// File: tb/sim_irqc_top.sv
module sim_irqc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] pri_src = '0;
    logic [31:0] sec_src = '0;
    logic [9:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irqc_top u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .pri_src  (pri_src),
        .sec_src  (sec_src),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rd   (bus_rd),
        .bus_rdata(bus_rdata),
        .cpu_irq  (cpu_irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_check(input string req, input logic [9:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic t_reset();
        rd_check("R1 pend0", 10'h010, 0);
        rd_check("R1 pend1", 10'h014, 0);
        rd_check("R1 en0", 10'h020, 0);
        rd_check("R1 en1", 10'h024, 0);
        rd_check("R1 sstat", 10'h080, 0);
        rd_check("R1 sen", 10'h090, 0);
        rd_check("R1 index", 10'h040, 0);
        check("R1 irq", 32'(cpu_irq), 0);
        rd_check("R1 route0", 10'h200, 0);
        rd_check("R1 route5", 10'h214, 5);
        rd_check("R1 route39", 10'h29C, 39);
    endtask

    task automatic t_enable();
        wr(10'h020, 32'h0000_0100);
        rd_check("R3 set bit8", 10'h020, 32'h0000_0100);
        wr(10'h020, 32'h0000_0001);
        rd_check("R3 zeros keep", 10'h020, 32'h0000_0101);
        wr(10'h030, 32'h0000_0100);
        rd_check("R4 clear bit8", 10'h034 - 10'h004, 32'h0000_0001);
        wr(10'h030, 32'h0000_0001);
        rd_check("R4 clear all", 10'h020, 0);
        wr(10'h024, 32'hFFFF_FFFF);
        rd_check("R13 upper word", 10'h024, 32'h0000_00FF);
        wr(10'h034, 32'hFFFF_FFFF);
        rd_check("R4 upper clear", 10'h024, 0);
    endtask

    task automatic t_level();
        @(negedge clk); pri_src[5] = 1'b1;
        tick(1);
        check("R2 pend unenabled irq", 32'(cpu_irq), 0);
        rd_check("R2 pend latched", 10'h010, 32'h0000_0020);
        wr(10'h020, 32'h0000_0020);
        check("R10 irq on enable", 32'(cpu_irq), 1);
        rd_check("R8 index 5", 10'h040, 5);
        wr(10'h010, 32'h0000_0020);
        rd_check("R5 ack while high", 10'h010, 32'h0000_0020);
        @(negedge clk); pri_src[5] = 1'b0;
        rd_check("R5 still latched", 10'h010, 32'h0000_0020);
        wr(10'h010, 32'h0000_0020);
        rd_check("R5 ack when low", 10'h010, 0);
        check("R10 irq drops", 32'(cpu_irq), 0);
        wr(10'h030, 32'h0000_0020);
    endtask

    task automatic t_prio();
        @(negedge clk); pri_src[9] = 1'b1; pri_src[35] = 1'b1;
        tick(1);
        rd_check("R13 pend word1", 10'h014, 32'h0000_0008);
        wr(10'h024, 32'h0000_0008);
        rd_check("R8 only 35", 10'h040, 35);
        wr(10'h020, 32'h0000_0200);
        rd_check("R8 lowest 9", 10'h040, 9);
        wr(10'h030, 32'h0000_0200);
        rd_check("R8 back to 35", 10'h040, 35);
        @(negedge clk); pri_src = '0;
        wr(10'h010, 32'hFFFF_FFFF);
        wr(10'h014, 32'hFFFF_FFFF);
        wr(10'h034, 32'hFFFF_FFFF);
        check("R9 idle irq", 32'(cpu_irq), 0);
        rd_check("R9 idle index", 10'h040, 0);
    endtask

    task automatic t_secondary();
        @(negedge clk); sec_src = 32'h0000_0011; pri_src[7] = 1'b1;
        tick(2);
        rd_check("R6 status bits", 10'h080, 32'h0000_0011);
        rd_check("R7 not cascaded", 10'h010, 32'h0000_0080);
        wr(10'h090, 32'h0000_0010);
        rd_check("R6 sec enable", 10'h090, 32'h0000_0010);
        tick(1);
        rd_check("R7 cascaded", 10'h010, 32'h0000_0081);
        wr(10'h020, 32'h0000_0081);
        check("R10 irq cascade", 32'(cpu_irq), 1);
        rd_check("R9 index aux", 10'h040, 0);
        wr(10'h030, 32'h0000_0001);
        rd_check("R8 index 7", 10'h040, 7);
        @(negedge clk); sec_src = '0; pri_src = '0;
        wr(10'h088, 32'hFFFF_FFFF);
        rd_check("R5 sec ack", 10'h088, 0);
        wr(10'h098, 32'hFFFF_FFFF);
        rd_check("R4 sec disable", 10'h098, 0);
        wr(10'h010, 32'hFFFF_FFFF);
        wr(10'h030, 32'hFFFF_FFFF);
        rd_check("R5 main cleared", 10'h010, 0);
        check("R10 irq quiet", 32'(cpu_irq), 0);
    endtask

    task automatic t_route();
        wr(10'h20C, 32'hFFFF_FFE5);
        rd_check("R11 entry3", 10'h20C, 32'h0000_0025);
        rd_check("R11 entry1 kept", 10'h204, 1);
        rd_check("R11 entry4 kept", 10'h210, 4);
        rd_check("R12 unmapped 0x300", 10'h300, 0);
        rd_check("R12 unmapped 0x000", 10'h000, 0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_enable();
        t_level();
        t_prio();
        t_secondary();
        t_route();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule